// File: doc/BRIEF.md
# Capture/Compare Timer with One-Shot Output

This block is a 16-bit up-counter with two capture/compare channels and a one-shot pulse generator. The counter advances on a count strobe. That strobe is either the rising phase of a prescaled count clock or an already filtered external edge event. The counter can run freely. It can also restart from zero on each external edge, or restart from zero after it reaches the value held in channel 0. The prescaler and the input noise filter are separate blocks that feed this one through strobes.

Each channel holds a register that works in one of two ways. As a compare register it is loaded by software and raises a match pulse. As a capture register it takes a snapshot of the counter when its trigger has stayed high long enough. The snapshot is taken on the falling phase of the count clock. The capture interrupt waits for the next rising phase. The one-shot output rises on a software or edge trigger and falls when the counter reaches channel 1. It is refused in the compare-clear mode.

A simple read port selects the counter or either channel register. Reading has no side effects.

Top module: `cct_timer`

## Requirements
- R1: While `run` is low the counter holds its value. In the clock after `run` rises, the counter reads 0. While running, each count strobe adds one.
- R2: When the counter advances from 0xFFFF it becomes 0x0000, and `ovf` is high for exactly that one clock.
- R3: With `mode`=2 (clear on compare), a count strobe that finds the counter equal to channel 0 loads 0 instead of incrementing. A count strobe that finds the counter equal to a compare-mode channel i raises `irq_cmp[i]` for one clock in the next cycle.
- R4: With `mode`=1 (clear on edge) and `src_ext`=0, an `ext_edge` pulse while running clears the counter to 0 on the next clock. This takes priority over a count strobe in the same cycle. Modes 0 and 3 are free running.
- R5: A channel with `cap_sel[i]`=1 captures the counter value present in a `tick_fall` cycle only when `cap_trig[i]` is high in that cycle and at the previous `tick_fall`, and was low at the `tick_fall` before that. A capture happens at most once per assertion of the trigger.
- R6: A capture sets a pending flag. At the next `tick_rise` cycle, `irq_cap[i]` pulses for one clock in the following cycle.
- R7: A channel with `cap_sel[i]`=0 (compare mode) never takes a capture. Only a software write changes it.
- R8: With `src_ext`=1 the counter advances on `ext_edge` instead of `tick_rise`. Channel 0 then ignores its capture trigger.
- R9: `rd_data` shows the counter for `rd_sel`=0, channel 0 for 1, channel 1 for 2, and zero for 3. Reading changes no state.
- R10: With `os_en`=1 and `mode`≠2, an `os_sw` pulse or an `ext_edge` (with `src_ext`=0) raises `os_out` on the next clock. `os_out` falls after a count strobe that finds the counter equal to channel 1. Triggers are ignored while it is high.
- R11: With `mode`=2, or with `os_en`=0, `os_out` is low from the next clock onward.
- R12: `wr_en` with `wr_sel`=0 or 1 loads `wr_data` into that channel on the next clock. A capture in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_rise | input | 1 | Count-clock rising-phase strobe |
| tick_fall | input | 1 | Count-clock falling-phase strobe |
| run | input | 1 | Counting enable; rising edge restarts from 0 |
| mode | input | 2 | 0/3 free run, 1 clear on edge, 2 clear on compare |
| src_ext | input | 1 | Count on ext_edge instead of tick_rise |
| ext_edge | input | 1 | Filtered external edge event |
| cap_sel | input | 2 | Per channel: 1 capture, 0 compare |
| cap_trig | input | 2 | Filtered capture trigger levels |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 1 | Write target channel |
| wr_data | input | W | Write value |
| rd_sel | input | 2 | Read select |
| rd_data | output | W | Read value |
| os_en | input | 1 | One-shot output enable |
| os_sw | input | 1 | Software one-shot trigger |
| os_out | output | 1 | One-shot pulse output |
| ovf | output | 1 | Counter wrap pulse |
| irq_cmp | output | 2 | Compare match pulses |
| irq_cap | output | 2 | Capture interrupt pulses |

## Verification
A wrong count or a bad wrap shows on `rd_data` in the very next clock, because the bench compares the read port against its model every cycle. A bad trigger-history state shows as a capture that is missing or extra. That in turn shows as a wrong channel value at the next read and a wrong `irq_cap` at the next rising phase, at most four clocks later. A stuck pending flag or a stuck one-shot state shows as a pulse on `irq_cap` or `os_out` that the model does not expect, in the cycle after the strobe that should have ended it.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int NCH = 2;

    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_EXTCLR = 2'd1,
        MODE_CMPCLR = 2'd2,
        MODE_FREE2  = 2'd3
    } tmr_mode_e;

    // trigger levels seen at the last two falling phases
    typedef struct packed {
        logic s0;
        logic s1;
    } trig_hist_t;

    function automatic logic qualify(trig_hist_t h, logic now);
        return now & h.s0 & ~h.s1;
    endfunction

    function automatic trig_hist_t shift_hist(trig_hist_t h, logic now);
        trig_hist_t r;
        r.s0 = now;
        r.s1 = h.s0;
        return r;
    endfunction

endpackage

// File: rtl/cct_counter.sv
module cct_counter
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  tmr_mode_e    mode,
    input  logic         src_ext,
    input  logic         tick_rise,
    input  logic         ext_edge,
    input  logic [W-1:0] cr0,
    output logic [W-1:0] cnt,
    output logic         ovf,
    output logic         step
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic run_q, adv, ext_clr, start, cmp_hit;

    always_comb begin
        adv     = src_ext ? ext_edge : tick_rise;
        ext_clr = (mode == MODE_EXTCLR) && ext_edge && !src_ext;
        start   = run && !run_q;
        step    = run && run_q && adv && !ext_clr;
        cmp_hit = (mode == MODE_CMPCLR) && (cnt == cr0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            run_q <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            run_q <= run;
            ovf   <= 1'b0;
            if (run && (start || ext_clr)) begin
                cnt <= '0;
            end else if (step) begin
                if (cmp_hit) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                    ovf <= (cnt == CNT_MAX);
                end
            end
        end
    end

    assert_start_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |=> (cnt == '0));
    assert_hold_stopped_R1: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt));
    assert_ovf_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (cnt == '0));
    assert_cmp_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (step && mode == MODE_CMPCLR && cnt == cr0) |=> (cnt == '0));
    assert_ext_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (run && mode == MODE_EXTCLR && ext_edge && !src_ext) |=> (cnt == '0));

endmodule

// File: rtl/cct_channel.sv
module cct_channel
    import cct_pkg::*;
#(
    parameter int W   = 16,
    parameter int IDX = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_mode,
    input  logic         src_ext,
    input  logic         tick_fall,
    input  logic         tick_rise,
    input  logic         trig,
    input  logic         step,
    input  logic [W-1:0] cnt,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cr,
    output logic         irq_cmp,
    output logic         irq_cap
);
    trig_hist_t hist;
    logic pend, blocked, take;

    always_comb begin
        blocked = (IDX == 0) && src_ext;
        take    = tick_fall && qualify(hist, trig) && cap_mode && !blocked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist    <= '0;
            pend    <= 1'b0;
            cr      <= '0;
            irq_cmp <= 1'b0;
            irq_cap <= 1'b0;
        end else begin
            if (tick_fall) hist <= shift_hist(hist, trig);
            irq_cmp <= step && !cap_mode && (cnt == cr);
            irq_cap <= tick_rise && pend;
            if (tick_rise) pend <= 1'b0;
            if (take) pend <= 1'b1;
            if (take) cr <= cnt;
            else if (wr_hit) cr <= wr_data;
        end
    end

    assert_fall_only_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_hit && !tick_fall) |=> $stable(cr));
    assert_cap_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        irq_cap |=> !irq_cap);
    assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!cap_mode && !wr_hit) |=> $stable(cr));

    if (IDX == 0) begin : g_src_block
        assert_ext_block_R8: assert property (@(posedge clk) disable iff (rst)
            (src_ext && !wr_hit) |=> $stable(cr));
    end

endmodule

// File: rtl/cct_oneshot.sv
module cct_oneshot
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         os_en,
    input  tmr_mode_e    mode,
    input  logic         os_sw,
    input  logic         ext_edge,
    input  logic         src_ext,
    input  logic         step,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cr1,
    output logic         os_out
);
    logic allowed, fire, done;

    always_comb begin
        allowed = os_en && (mode != MODE_CMPCLR);
        fire    = os_sw || (ext_edge && !src_ext);
        done    = step && (cnt == cr1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            os_out <= 1'b0;
        end else if (!allowed) begin
            os_out <= 1'b0;
        end else if (!os_out && fire) begin
            os_out <= 1'b1;
        end else if (os_out && done) begin
            os_out <= 1'b0;
        end
    end

    assert_no_spont_rise_R10: assert property (@(posedge clk) disable iff (rst)
        (!os_out && !os_sw && !ext_edge) |=> !os_out);
    assert_refused_R11: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CMPCLR || !os_en) |=> !os_out);

endmodule

// File: rtl/cct_timer.sv
module cct_timer
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_rise,
    input  logic         tick_fall,
    input  logic         run,
    input  logic [1:0]   mode,
    input  logic         src_ext,
    input  logic         ext_edge,
    input  logic [1:0]   cap_sel,
    input  logic [1:0]   cap_trig,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    input  logic         os_en,
    input  logic         os_sw,
    output logic         os_out,
    output logic         ovf,
    output logic [1:0]   irq_cmp,
    output logic [1:0]   irq_cap
);
    tmr_mode_e    mode_e;
    logic [W-1:0] cnt;
    logic         step;
    logic [W-1:0] cr [NCH];

    assign mode_e = tmr_mode_e'(mode);

    cct_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .mode(mode_e), .src_ext(src_ext),
        .tick_rise(tick_rise), .ext_edge(ext_edge), .cr0(cr[0]),
        .cnt(cnt), .ovf(ovf), .step(step)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cct_channel #(.W(W), .IDX(i)) u_ch (
            .clk(clk), .rst(rst), .cap_mode(cap_sel[i]), .src_ext(src_ext),
            .tick_fall(tick_fall), .tick_rise(tick_rise), .trig(cap_trig[i]),
            .step(step), .cnt(cnt),
            .wr_hit(wr_en && (wr_sel == 1'(i))), .wr_data(wr_data),
            .cr(cr[i]), .irq_cmp(irq_cmp[i]), .irq_cap(irq_cap[i])
        );
    end

    cct_oneshot #(.W(W)) u_os (
        .clk(clk), .rst(rst), .os_en(os_en), .mode(mode_e), .os_sw(os_sw),
        .ext_edge(ext_edge), .src_ext(src_ext), .step(step), .cnt(cnt),
        .cr1(cr[1]), .os_out(os_out)
    );

    always_comb begin
        case (rd_sel)
            2'd0:    rd_data = cnt;
            2'd1:    rd_data = cr[0];
            2'd2:    rd_data = cr[1];
            default: rd_data = '0;
        endcase
    end

endmodule

// File: tb/sim_cct_timer.sv
module sim_cct_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_rise = 0, tick_fall = 0, run = 0, src_ext = 0, ext_edge = 0;
    logic [1:0]  mode = 0, cap_sel = 0, cap_trig = 0, rd_sel = 0;
    logic        wr_en = 0, wr_sel = 0, os_en = 0, os_sw = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data;
    logic        os_out, ovf;
    logic [1:0]  irq_cmp, irq_cap;

    cct_timer #(.W(16)) u0 (
        .clk(clk), .rst(rst), .tick_rise(tick_rise), .tick_fall(tick_fall),
        .run(run), .mode(mode), .src_ext(src_ext), .ext_edge(ext_edge),
        .cap_sel(cap_sel), .cap_trig(cap_trig), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .os_en(os_en),
        .os_sw(os_sw), .os_out(os_out), .ovf(ovf), .irq_cmp(irq_cmp), .irq_cap(irq_cap)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0, ph = 0, ovf_seen = 0;
    bit done = 0;

    // behavioural reference model
    int m_cnt, m_cr[2];
    bit m_runq, m_ovf, m_os;
    bit m_s0[2], m_s1[2], m_pend[2], m_icap[2], m_icmp[2];
    int n_cnt, n_cr[2];
    bit n_ovf, n_os, a_adv, a_clr, a_step, a_take, a_ok, a_fire;
    bit n_s0[2], n_s1[2], n_pend[2], n_icap[2], n_icmp[2];

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_runq = 0; m_ovf = 0; m_os = 0;
            for (int i = 0; i < 2; i++) begin
                m_cr[i] = 0; m_s0[i] = 0; m_s1[i] = 0;
                m_pend[i] = 0; m_icap[i] = 0; m_icmp[i] = 0;
            end
        end else begin
            a_adv  = src_ext ? ext_edge : tick_rise;
            a_clr  = (mode == 2'd1) && ext_edge && !src_ext;
            a_step = run && m_runq && a_adv && !a_clr;
            n_cnt = m_cnt; n_ovf = 0;
            if (run && (!m_runq || a_clr)) n_cnt = 0;
            else if (a_step) begin
                if (mode == 2'd2 && m_cnt == m_cr[0]) n_cnt = 0;
                else begin n_cnt = (m_cnt + 1) & 16'hFFFF; n_ovf = (m_cnt == 16'hFFFF); end
            end
            for (int i = 0; i < 2; i++) begin
                a_take = tick_fall && cap_trig[i] && m_s0[i] && !m_s1[i]
                         && cap_sel[i] && !(i == 0 && src_ext);
                n_s0[i] = tick_fall ? cap_trig[i] : m_s0[i];
                n_s1[i] = tick_fall ? m_s0[i] : m_s1[i];
                n_icmp[i] = a_step && !cap_sel[i] && (m_cnt == m_cr[i]);
                n_icap[i] = tick_rise && m_pend[i];
                n_pend[i] = tick_rise ? 1'b0 : m_pend[i];
                if (a_take) n_pend[i] = 1;
                n_cr[i] = m_cr[i];
                if (a_take) n_cr[i] = m_cnt;
                else if (wr_en && wr_sel == i[0]) n_cr[i] = wr_data;
            end
            a_ok = os_en && mode != 2'd2;
            a_fire = os_sw || (ext_edge && !src_ext);
            n_os = m_os;
            if (!a_ok) n_os = 0;
            else if (!m_os && a_fire) n_os = 1;
            else if (m_os && a_step && m_cnt == m_cr[1]) n_os = 0;
            m_cnt = n_cnt; m_ovf = n_ovf; m_os = n_os; m_runq = run;
            for (int i = 0; i < 2; i++) begin
                m_cr[i] = n_cr[i]; m_s0[i] = n_s0[i]; m_s1[i] = n_s1[i];
                m_pend[i] = n_pend[i]; m_icap[i] = n_icap[i]; m_icmp[i] = n_icmp[i];
            end
        end
    end

    function automatic int exp_rd(logic [1:0] s);
        case (s)
            2'd0: return m_cnt;
            2'd1: return m_cr[0];
            2'd2: return m_cr[1];
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (ovf) ovf_seen++;
            chk("R9 rd_data", int'(rd_data), exp_rd(rd_sel));
            chk("R2 ovf", int'(ovf), int'(m_ovf));
            chk("R3 irq_cmp", int'(irq_cmp), int'({m_icmp[1], m_icmp[0]}));
            chk("R6 irq_cap", int'(irq_cap), int'({m_icap[1], m_icap[0]}));
            chk("R10 os_out", int'(os_out), int'(m_os));
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk); #2;
            tick_rise = (ph % 4 == 0);
            tick_fall = (ph % 4 == 2);
            ph++;
        end
    endtask

    task automatic summary();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    int v;
    initial begin
        tick(3);
        rst = 0;
        @(negedge clk);
        chk("R1 reset count", int'(rd_data), 0);
        chk("R1 reset outputs", int'({os_out, ovf, irq_cmp, irq_cap}), 0);

        // R12: software loads of both channels, then free running with compares
        wr_en = 1; wr_sel = 0; wr_data = 16'd12; tick(1);
        wr_sel = 1; wr_data = 16'd30; tick(1);
        wr_en = 0; run = 1; tick(200);
        rd_sel = 1; @(negedge clk);
        chk("R12 write ch0", int'(rd_data), 12);

        // R1: hold while stopped, clear on restart
        run = 0; rd_sel = 0; tick(1);
        @(negedge clk); v = rd_data;
        tick(6); @(negedge clk);
        chk("R1 hold", int'(rd_data), v);
        run = 1; os_en = 1; tick(1); @(negedge clk);
        chk("R1 start clears", int'(rd_data), 0);

        // R10: one-shot rise, ignored retrigger, fall at channel 1
        os_sw = 1; tick(1); os_sw = 0; @(negedge clk);
        chk("R10 rise", int'(os_out), 1);
        tick(40); os_sw = 1; tick(1); os_sw = 0;
        tick(120); @(negedge clk);
        chk("R10 fall", int'(os_out), 0);

        // R3 / R11: compare-clear mode
        run = 0; tick(2); mode = 2; run = 1; tick(200);
        os_sw = 1; tick(1); os_sw = 0; @(negedge clk);
        chk("R11 refused", int'(os_out), 0);
        chk("R3 bounded", int'(rd_data <= 16'd12), 1);

        // R4: clear on external edge
        mode = 1;
        for (int k = 0; k < 3; k++) begin
            tick(25); ext_edge = 1; tick(1); ext_edge = 0;
            @(negedge clk);
            chk("R4 edge clear", int'(rd_data), 0);
        end
        os_en = 0;

        // R5 / R6: capture qualification
        mode = 0; cap_sel = 2'b11; rd_sel = 1;
        cap_trig = 2'b01; tick(2); cap_trig = 0; tick(10); @(negedge clk);
        chk("R5 short trigger", int'(rd_data), 12);
        cap_trig = 2'b01; tick(12); cap_trig = 0; tick(8); @(negedge clk);
        chk("R5 long trigger", int'(rd_data), exp_rd(2'd1));

        // R7: compare-mode channel keeps its value
        cap_sel = 2'b01; rd_sel = 2;
        cap_trig = 2'b10; tick(16); cap_trig = 0; tick(4); @(negedge clk);
        chk("R7 compare hold", int'(rd_data), 30);

        // R8: external count source blocks channel 0 capture
        wr_en = 1; wr_sel = 0; wr_data = 16'h1234; tick(1); wr_en = 0;
        cap_sel = 2'b11; src_ext = 1; cap_trig = 2'b01;
        for (int k = 0; k < 24; k++) begin ext_edge = k[0]; tick(1); end
        ext_edge = 0; cap_trig = 0; rd_sel = 1; tick(1); @(negedge clk);
        chk("R8 ch0 blocked", int'(rd_data), 16'h1234);

        // R2: wrap from all ones
        run = 0; tick(2); run = 1; ext_edge = 1; ovf_seen = 0; rd_sel = 0;
        tick(65540); ext_edge = 0; tick(1); @(negedge clk);
        chk("R2 wrapped count", int'(rd_data), exp_rd(2'd0));
        chk("R2 one overflow", ovf_seen, 1);

        // R9: unused select and side-effect-free reads
        src_ext = 0; rd_sel = 3; tick(1); @(negedge clk);
        chk("R9 unused select", int'(rd_data), 0);
        rd_sel = 1; tick(1); @(negedge clk); v = rd_data;
        for (int k = 0; k < 6; k++) begin rd_sel = 2'(k % 3); tick(1); end
        rd_sel = 1; tick(1); @(negedge clk);
        chk("R9 read no side effect", int'(rd_data), v);

        summary();
    end
endmodule